// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block is a small sequencer that runs from a free-running oscillator clock and moves the rest of the design between a running state and a low-power sleep state. A single external pin requests sleep while it sits at its sleep level and requests wake when it returns to the other level. The pin is brought into the oscillator domain through two flip-flops, then filtered so that short glitches are rejected.

Going to sleep, the controller first stops the gated core clock. After a programmable wait it powers down the input buffers of the selected I/O banks and tri-states every output buffer. Waking up runs the same steps in reverse: the buffers come back first, and the core clock is enabled again only after a programmable settling time. Every buffer control is active low. A 1 keeps the buffer working and a 0 powers it down or tri-states it. Banks 0 and 1 share one control line. A status output shows which of the four phases the controller is in. A change on the pin during a transition does nothing until that transition has finished.

Top module: `slp_pwr_ctrl`

## Requirements
- R1: `osc_en_o` is 1 in every cycle, both during reset and after it.
- R2: While `rst_n` is low, and immediately when it goes low (asynchronous), `gclk_en_o`, every bit of `in_pwr_n_o` and every bit of `oe_n_o` are 1, and `status_o` is 0 (ACTIVE).
- R3: The pin passes through a two-flop synchronizer. Its level is accepted only after the synchronized value has differed from the accepted level for `DEBOUNCE_CYCLES` consecutive cycles. A pulse shorter than that has no effect on any output.
- R4: On an accepted sleep request, `gclk_en_o` goes to 0 in the same cycle that `status_o` becomes 1 (ENTERING). The buffer controls stay at 1 for exactly `ENTRY_WAIT` cycles. After that, `status_o` becomes 2 (SLEEP) and the buffer controls go to their sleep values.
- R5: On an accepted wake request, `status_o` becomes 3 (EXITING) and all buffer controls return to 1 while `gclk_en_o` is still 0. After exactly `EXIT_SETTLE` cycles, `status_o` becomes 0 and `gclk_en_o` becomes 1.
- R6: Bit 0 and bit 1 of `in_pwr_n_o` are one shared line. Both follow bit 0 of `SLEEP_BANK_MASK`, and bit 1 of the mask is ignored.
- R7: In SLEEP, `in_pwr_n_o[b]` is 0 for each bank b ≥ 2 whose `SLEEP_BANK_MASK` bit is 1, and it stays 1 for each such bank whose mask bit is 0. Every bit of `oe_n_o` is 0.
- R8: A change of the pin level during ENTERING or EXITING does not shorten or abort the transition. The filtered level is evaluated again only once ACTIVE or SLEEP has been reached.
- R9: `status_o` encodes 0 = ACTIVE, 1 = ENTERING, 2 = SLEEP, 3 = EXITING. `SLEEP_LEVEL` picks the pin level that means sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_pin | input | 1 | External sleep/wake request pin, asynchronous |
| osc_en_o | output | 1 | Oscillator enable, held at 1 |
| gclk_en_o | output | 1 | Enable for the gated core clock |
| in_pwr_n_o | output | NUM_BANKS | Per-bank input buffer power control, 0 = powered down |
| oe_n_o | output | NUM_OUT | Per-buffer output enable, 0 = tri-stated |
| status_o | output | 2 | Controller phase |

## Verification
A clean sleep-then-wake cycle is sampled on the cycles around each edge. This shows whether the clock gate and the buffer controls change in the specified order, and whether each wait lasts exactly its programmed length. A pin pulse one cycle shorter than the debounce window is checked against a held level, which separates a correct filter from a missing or short one. Pin reversals placed inside ENTERING and inside EXITING show whether the transitions are protected. A bank mask with bank 1 cleared and one upper bank cleared shows whether the first pair is tied together and whether the per-bank selection works. A reset asserted while asleep shows whether the defaults are restored asynchronously.

// File: rtl/slp_pkg.sv
package slp_pkg;
   typedef enum logic [1:0] {
      ST_ACTIVE = 2'd0,
      ST_ENTER  = 2'd1,
      ST_SLEEP  = 2'd2,
      ST_EXIT   = 2'd3
   } slp_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/slp_pin_filter.sv
module slp_pin_filter #(
   parameter int unsigned DEBOUNCE_CYCLES = 4,
   parameter bit          SLEEP_LEVEL     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic req_o
);
   localparam int unsigned CW = $clog2(DEBOUNCE_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

   if (DEBOUNCE_CYCLES < 1) begin : g_bad_deb
      $error("DEBOUNCE_CYCLES must be at least 1");
   end

   logic pin_norm;
   if (SLEEP_LEVEL) begin : g_high_sleep
      assign pin_norm = pin;
   end else begin : g_low_sleep
      assign pin_norm = ~pin;
   end

   logic          sync_a, sync_b;
   logic          level_q;
   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_a <= 1'b0;
         sync_b <= 1'b0;
      end else begin
         sync_a <= pin_norm;
         sync_b <= sync_a;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         run_q   <= '0;
      end else if (sync_b == level_q) begin
         run_q <= '0;
      end else if (run_q == LAST) begin
         level_q <= sync_b;
         run_q   <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   assign req_o = level_q;

   // R3: the accepted level only ever moves to the synchronized value
   assert_level_from_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(level_q) |-> ($past(sync_b) == level_q));
   // R3: the run counter never passes the debounce window
   assert_run_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= LAST);
endmodule

// File: rtl/slp_seq_fsm.sv
module slp_seq_fsm
   import slp_pkg::*;
#(
   parameter int unsigned ENTRY_WAIT  = 3,
   parameter int unsigned EXIT_SETTLE = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   output slp_state_e state_o,
   output logic       gclk_en_o,
   output logic       io_on_o
);
   localparam int unsigned CW = $clog2(max2(ENTRY_WAIT, EXIT_SETTLE) + 1);
   localparam logic [CW-1:0] ENTER_LAST = CW'(ENTRY_WAIT - 1);
   localparam logic [CW-1:0] EXIT_LAST  = CW'(EXIT_SETTLE - 1);

   if (ENTRY_WAIT < 1 || EXIT_SETTLE < 1) begin : g_bad_wait
      $error("ENTRY_WAIT and EXIT_SETTLE must be at least 1");
   end

   slp_state_e    st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          gclk_q, io_q;

   always_comb begin
      st_d  = st_q;
      cnt_d = '0;
      unique case (st_q)
         ST_ACTIVE: if (req) st_d = ST_ENTER;
         ST_ENTER: begin
            if (cnt_q == ENTER_LAST) st_d = ST_SLEEP;
            else cnt_d = cnt_q + 1'b1;
         end
         ST_SLEEP: if (!req) st_d = ST_EXIT;
         ST_EXIT: begin
            if (cnt_q == EXIT_LAST) st_d = ST_ACTIVE;
            else cnt_d = cnt_q + 1'b1;
         end
         default: st_d = ST_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_ACTIVE;
         cnt_q  <= '0;
         gclk_q <= 1'b1;
         io_q   <= 1'b1;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         gclk_q <= (st_d == ST_ACTIVE);
         io_q   <= (st_d != ST_SLEEP);
      end
   end

   assign state_o   = st_q;
   assign gclk_en_o = gclk_q;
   assign io_on_o   = io_q;

   // R8: an unfinished entry stays in ENTERING whatever the request does
   assert_enter_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ENTER && cnt_q != ENTER_LAST) |=> (st_q == ST_ENTER));
   // R8: an unfinished exit stays in EXITING whatever the request does
   assert_exit_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_EXIT && cnt_q != EXIT_LAST) |=> (st_q == ST_EXIT));
   // R9: phases follow the fixed ring ACTIVE, ENTERING, SLEEP, EXITING
   assert_ring_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ENTER) |=> (st_q == ST_ENTER || st_q == ST_SLEEP));
   // R4: SLEEP is only reached through ENTERING
   assert_sleep_via_enter_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == ST_SLEEP) |-> ($past(st_q) == ST_ENTER));
endmodule

// File: rtl/slp_io_drive.sv
module slp_io_drive #(
   parameter int unsigned          NUM_BANKS       = 8,
   parameter int unsigned          NUM_OUT         = 12,
   parameter logic [NUM_BANKS-1:0] SLEEP_BANK_MASK = '1
) (
   input  logic                 io_on,
   output logic [NUM_BANKS-1:0] in_pwr_n_o,
   output logic [NUM_OUT-1:0]   oe_n_o
);
   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("NUM_BANKS must be at least 2 (first pair is shared)");
   end
   if (NUM_OUT < 1) begin : g_bad_out
      $error("NUM_OUT must be at least 1");
   end

   logic pair_line;
   assign pair_line = io_on | ~SLEEP_BANK_MASK[0];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      if (b < 2) begin : g_pair
         assign in_pwr_n_o[b] = pair_line;
      end else begin : g_single
         assign in_pwr_n_o[b] = io_on | ~SLEEP_BANK_MASK[b];
      end
   end

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_oe
      assign oe_n_o[k] = io_on;
   end
endmodule

// File: rtl/slp_pwr_ctrl.sv
module slp_pwr_ctrl
   import slp_pkg::*;
#(
   parameter int unsigned          NUM_BANKS       = 8,
   parameter int unsigned          NUM_OUT         = 12,
   parameter int unsigned          DEBOUNCE_CYCLES = 4,
   parameter int unsigned          ENTRY_WAIT      = 3,
   parameter int unsigned          EXIT_SETTLE     = 3,
   parameter bit                   SLEEP_LEVEL     = 1'b1,
   parameter logic [NUM_BANKS-1:0] SLEEP_BANK_MASK = '1
) (
   input  logic                 clk_osc,
   input  logic                 rst_n,
   input  logic                 sleep_pin,
   output logic                 osc_en_o,
   output logic                 gclk_en_o,
   output logic [NUM_BANKS-1:0] in_pwr_n_o,
   output logic [NUM_OUT-1:0]   oe_n_o,
   output logic [1:0]           status_o
);
   logic       req;
   logic       io_on;
   slp_state_e state;
   logic       osc_q;

   always_ff @(posedge clk_osc or negedge rst_n) begin
      if (!rst_n) osc_q <= 1'b1;
      else        osc_q <= 1'b1;
   end
   assign osc_en_o = osc_q;

   slp_pin_filter #(
      .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
      .SLEEP_LEVEL    (SLEEP_LEVEL)
   ) u_filter (
      .clk  (clk_osc),
      .rst_n(rst_n),
      .pin  (sleep_pin),
      .req_o(req)
   );

   slp_seq_fsm #(
      .ENTRY_WAIT (ENTRY_WAIT),
      .EXIT_SETTLE(EXIT_SETTLE)
   ) u_fsm (
      .clk      (clk_osc),
      .rst_n    (rst_n),
      .req      (req),
      .state_o  (state),
      .gclk_en_o(gclk_en_o),
      .io_on_o  (io_on)
   );

   slp_io_drive #(
      .NUM_BANKS      (NUM_BANKS),
      .NUM_OUT        (NUM_OUT),
      .SLEEP_BANK_MASK(SLEEP_BANK_MASK)
   ) u_drive (
      .io_on     (io_on),
      .in_pwr_n_o(in_pwr_n_o),
      .oe_n_o    (oe_n_o)
   );

   assign status_o = state;

   // R4: outputs are tri-stated only after the clock has been off for a cycle
   assert_io_down_after_gate_R4: assert property (@(posedge clk_osc) disable iff (!rst_n)
      $fell(oe_n_o[0]) |-> (!gclk_en_o && !$past(gclk_en_o)));
   // R5: the clock returns only after the buffers were already back
   assert_clock_after_io_R5: assert property (@(posedge clk_osc) disable iff (!rst_n)
      $rose(gclk_en_o) |-> ((&oe_n_o) && $past(&oe_n_o)));
   // R7: in SLEEP no output buffer is driving
   assert_sleep_tristate_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (status_o == 2'd2) |-> (oe_n_o == '0));
endmodule

// File: tb/test_slp_pwr_ctrl.sv
`timescale 1ns/1ps
module test_slp_pwr_ctrl;
   localparam int unsigned NB = 8;
   localparam int unsigned NO = 12;
   localparam logic [NB-1:0] MASK = 8'hDD;   // bank1 and bank5 cleared

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pin = 1'b0;
   logic          osc_en, gclk_en;
   logic [NB-1:0] in_pwr_n;
   logic [NO-1:0] oe_n;
   logic [1:0]    status;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   slp_pwr_ctrl #(
      .NUM_BANKS(NB), .NUM_OUT(NO), .DEBOUNCE_CYCLES(4),
      .ENTRY_WAIT(3), .EXIT_SETTLE(3), .SLEEP_LEVEL(1'b1),
      .SLEEP_BANK_MASK(MASK)
   ) i_slp_pwr_ctrl (
      .clk_osc(clk), .rst_n(rst_n), .sleep_pin(pin),
      .osc_en_o(osc_en), .gclk_en_o(gclk_en), .in_pwr_n_o(in_pwr_n),
      .oe_n_o(oe_n), .status_o(status)
   );

   function automatic logic [NB-1:0] sleep_banks();
      logic [NB-1:0] v;
      for (int b = 0; b < NB; b++) v[b] = (b < 2) ? ~MASK[0] : ~MASK[b];
      return v;
   endfunction

   task automatic check(input string tag, input logic [1:0] st, input logic gclk,
                        input logic io);
      logic [NB-1:0] e_in;
      logic [NO-1:0] e_oe;
      e_in = io ? '1 : sleep_banks();
      e_oe = io ? '1 : '0;
      checks++;
      if (status !== st || gclk_en !== gclk || in_pwr_n !== e_in || oe_n !== e_oe
          || osc_en !== 1'b1) begin
         fails++;
         $display("FAIL %s: st=%0d gclk=%b in=%b oe=%b osc=%b expected st=%0d gclk=%b in=%b oe=%b osc=1",
                  tag, status, gclk_en, in_pwr_n, oe_n, osc_en, st, gclk, e_in, e_oe);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   typedef struct packed {
      logic       pin;
      logic [7:0] wt;
      logic [1:0] st;
      logic       gclk;
      logic       io;
   } vec_t;

   // clean sleep then wake; waits are cycles since the previous row
   localparam vec_t VEC [8] = '{
      '{1'b1, 8'd6, 2'd0, 1'b1, 1'b1},   // R3 level accepted, not yet acted on
      '{1'b1, 8'd1, 2'd1, 1'b0, 1'b1},   // R4 clock gated first
      '{1'b1, 8'd2, 2'd1, 1'b0, 1'b1},   // R4 last wait cycle
      '{1'b1, 8'd1, 2'd2, 1'b0, 1'b0},   // R4 R7 R6 buffers down
      '{1'b0, 8'd6, 2'd2, 1'b0, 1'b0},   // R3 wake accepted, still asleep
      '{1'b0, 8'd1, 2'd3, 1'b0, 1'b1},   // R5 buffers back, clock still off
      '{1'b0, 8'd2, 2'd3, 1'b0, 1'b1},   // R5 settling
      '{1'b0, 8'd1, 2'd0, 1'b1, 1'b1}    // R5 R9 clock back
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      wait_cyc(3);
      check("R2 R1 defaults during reset", 2'd0, 1'b1, 1'b1);
      rst_n = 1'b1;
      wait_cyc(2);
      check("R2 R1 defaults after reset", 2'd0, 1'b1, 1'b1);

      for (int i = 0; i < 8; i++) begin
         pin = VEC[i].pin;
         wait_cyc(int'(VEC[i].wt));
         check($sformatf("vector %0d R4 R5 R7 R9", i), VEC[i].st, VEC[i].gclk, VEC[i].io);
      end

      // R3: pulse one cycle shorter than the debounce window
      pin = 1'b1; wait_cyc(3); pin = 1'b0; wait_cyc(12);
      check("R3 short pulse ignored", 2'd0, 1'b1, 1'b1);

      // R8: wake request during ENTERING
      pin = 1'b1; wait_cyc(7);
      check("R8 entering", 2'd1, 1'b0, 1'b1);
      pin = 1'b0; wait_cyc(3);
      check("R8 entry completes despite wake", 2'd2, 1'b0, 1'b0);
      checks++;
      if (in_pwr_n[0] !== in_pwr_n[1] || in_pwr_n[0] !== 1'b0 || in_pwr_n[5] !== 1'b1) begin
         fails++;
         $display("FAIL R6 R7 bank lines: in=%b expected bit0=bit1=0 bit5=1", in_pwr_n);
      end
      wait_cyc(4);
      check("R8 exit after sleep reached", 2'd3, 1'b0, 1'b1);
      // R8: sleep request during EXITING
      pin = 1'b1; wait_cyc(3);
      check("R8 exit completes despite sleep", 2'd0, 1'b1, 1'b1);
      wait_cyc(4);
      check("R8 re-entry after active reached", 2'd1, 1'b0, 1'b1);
      wait_cyc(3);
      check("R4 asleep again", 2'd2, 1'b0, 1'b0);

      // R2: reset while asleep restores defaults at once
      pin = 1'b0;
      rst_n = 1'b0; #0.5;
      check("R2 async reset from sleep", 2'd0, 1'b1, 1'b1);
      wait_cyc(2);
      rst_n = 1'b1;
      wait_cyc(12);
      check("R2 stays active after reset", 2'd0, 1'b1, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule